// File: doc/BRIEF.md
# Two-Program Reconfigure-and-Run Sequencer

This block drives a compute core that owns one swappable execution unit and has to run two programs in turn, each of which depends on a different unit image. Before either program may start, the sequencer asks the reconfiguration engine to load the image that program needs. It waits until the engine reports that loading is complete, then enables the core and waits for the program to end. It then moves to the other program and repeats this without end. A core is therefore never started on a unit that does not match its program.

On the engine side the sequencer offers a one-cycle request strobe and an image index, and it observes the engine's ready and done signals. On the core side it drives a level enable and observes the core's busy line and its result strobe. The first start command takes the block out of its idle state. From then on the loop runs by itself until reset. A result strobe that arrives while no program is running sets an error flag, and that flag stays set until reset.

Top module: `pr_program_sequencer`

## Requirements
- R1: While reset is asserted (asynchronous, active low) and in the first cycle after it, `cfg_req`, `core_run` and `stray_result_err` are 0 and `cfg_image` holds the image of the first program. With the default parameters that image is 0.
- R2: After reset the block stays idle and issues no request, even with `cfg_ready` high, until `seq_go` is seen high at a clock edge.
- R3: `cfg_req` is high only while `cfg_ready` is high and a request is pending. Each request lasts exactly one cycle. While `cfg_ready` is low the pending request waits.
- R4: The first request after reset carries image 0. Every later request carries the other image (1, 0, 1, ...). `cfg_image` stays constant while `core_run` is high.
- R5: `core_run` stays low after a request until `cfg_done` is sampled high. It rises in the cycle after that edge.
- R6: `core_run` stays high until `core_busy` has been sampled high and then sampled low. It falls in the cycle after the edge at which `core_busy` is seen low.
- R7: When a program ends, `cfg_image` switches to the other program's image in the same cycle that `core_run` falls. No request is issued while `core_run` is high.
- R8: A `cfg_done` pulse while a request is still pending is ignored: `core_run` stays low and the request is still issued afterwards.
- R9: A `core_result_vld` pulse sampled while `core_run` is low sets `stray_result_err` in the next cycle. The flag then stays set, even through later program runs, until reset. Result pulses while `core_run` is high leave it at 0.
- R10: Once the block has left idle, taking `seq_go` low has no effect and the alternation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_go | input | 1 | Start command; takes the block out of idle |
| cfg_ready | input | 1 | Reconfiguration engine can accept a request |
| cfg_done | input | 1 | Reconfiguration engine finished loading |
| cfg_req | output | 1 | One-cycle request to load an image |
| cfg_image | output | IDX_W | Image index sent with the request |
| core_busy | input | 1 | Core is executing its program |
| core_result_vld | input | 1 | Core result strobe |
| core_run | output | 1 | Level enable for the compute core |
| stray_result_err | output | 1 | Sticky flag: result seen while no program ran |

## Verification
The checker watches several rules on every cycle: a request only ever appears together with ready and never spans two cycles, the enable only rises after a done, the image index holds steady while the core runs and changes each time the enable drops, the enable only drops after busy is seen low, and the error flag, once set, stays set and has a stray strobe as its cause. Other behaviour can only be shown by the bench's scenarios. These are the exact order of images across six program rounds with varied ready, done and busy timing, that nothing is requested while idle, that a done pulse arriving early is ignored, that the loop keeps running after the start command is dropped, and that a reset in the middle of a run restores the first image and clears the flag.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;

   // Phases of one program round; order is the order of progress.
   typedef enum logic [2:0] {
      PS_IDLE      = 3'd0,
      PS_REQ       = 3'd1,
      PS_WAIT_DONE = 3'd2,
      PS_RUN       = 3'd3,
      PS_WAIT_FIN  = 3'd4
   } pseq_state_e;

   function automatic logic is_running(input pseq_state_e s);
      return (s == PS_RUN) || (s == PS_WAIT_FIN);
   endfunction

endpackage

// File: rtl/pseq_fsm.sv
`timescale 1ns/1ps
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int FIRST_PROG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic rc_ready,
   input  logic rc_done,
   input  logic busy,
   output logic req,
   output logic run,
   output logic sel_q,
   output logic sel_d
);

   localparam logic SEL_RST = (FIRST_PROG != 0);

   pseq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      sel_d   = sel_q;
      case (state_q)
         PS_IDLE:      if (go)       state_d = PS_REQ;
         PS_REQ:       if (rc_ready) state_d = PS_WAIT_DONE;
         PS_WAIT_DONE: if (rc_done)  state_d = PS_RUN;
         PS_RUN:       if (busy)     state_d = PS_WAIT_FIN;
         PS_WAIT_FIN: begin
            if (!busy) begin
               state_d = PS_REQ;
               sel_d   = ~sel_q;
            end
         end
         default:                    state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         sel_q   <= SEL_RST;
      end else begin
         state_q <= state_d;
         sel_q   <= sel_d;
      end
   end

   assign req = (state_q == PS_REQ) && rc_ready;
   assign run = is_running(state_q);

endmodule

// File: rtl/pseq_index_map.sv
`timescale 1ns/1ps
module pseq_index_map #(
   parameter int IDX_W      = 1,
   parameter int IMG0       = 0,
   parameter int IMG1       = 1,
   parameter int FIRST_PROG = 0,
   parameter bit IDX_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_q,
   input  logic             sel_d,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] IDX_A   = IDX_W'(IMG0);
   localparam logic [IDX_W-1:0] IDX_B   = IDX_W'(IMG1);
   localparam logic [IDX_W-1:0] IDX_RST = (FIRST_PROG != 0) ? IDX_B : IDX_A;

   generate
      if (IDX_REG) begin : g_reg
         // Index comes straight from a flop; loaded from the next selection.
         logic [IDX_W-1:0] idx_q;
         logic             unused_sel_q;
         assign unused_sel_q = sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) idx_q <= IDX_RST;
            else        idx_q <= sel_d ? IDX_B : IDX_A;
         end
         assign idx = idx_q;
      end else begin : g_mux
         // Index decoded from the selection flop; no extra storage.
         logic unused_mux;
         assign unused_mux = ^{clk, rst_n, sel_d};
         assign idx = sel_q ? IDX_B : IDX_A;
      end
   endgenerate

endmodule

// File: rtl/pseq_err_mon.sv
`timescale 1ns/1ps
module pseq_err_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic res_valid,
   output logic err
);

   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | (res_valid & ~active);
   end

   assign err = err_q;

endmodule

// File: rtl/pr_program_sequencer.sv
`timescale 1ns/1ps
module pr_program_sequencer #(
   parameter int IDX_W      = 1,
   parameter int IMG0       = 0,
   parameter int IMG1       = 1,
   parameter int FIRST_PROG = 0,
   parameter bit IDX_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_go,
   input  logic             cfg_ready,
   input  logic             cfg_done,
   output logic             cfg_req,
   output logic [IDX_W-1:0] cfg_image,
   input  logic             core_busy,
   input  logic             core_result_vld,
   output logic             core_run,
   output logic             stray_result_err
);

   localparam longint IMG_LIMIT = longint'(1) << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_w
         $fatal(1, "pr_program_sequencer: IDX_W out of range");
      end
      if (IMG0 < 0 || longint'(IMG0) >= IMG_LIMIT ||
          IMG1 < 0 || longint'(IMG1) >= IMG_LIMIT) begin : g_bad_img
         $fatal(1, "pr_program_sequencer: image index does not fit IDX_W");
      end
      if (IMG0 == IMG1) begin : g_same_img
         $fatal(1, "pr_program_sequencer: both programs name one image");
      end
      if (FIRST_PROG != 0 && FIRST_PROG != 1) begin : g_bad_first
         $fatal(1, "pr_program_sequencer: FIRST_PROG must be 0 or 1");
      end
   endgenerate

   logic sel_q, sel_d;

   pseq_fsm #(
      .FIRST_PROG (FIRST_PROG)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (seq_go),
      .rc_ready (cfg_ready),
      .rc_done  (cfg_done),
      .busy     (core_busy),
      .req      (cfg_req),
      .run      (core_run),
      .sel_q    (sel_q),
      .sel_d    (sel_d)
   );

   pseq_index_map #(
      .IDX_W      (IDX_W),
      .IMG0       (IMG0),
      .IMG1       (IMG1),
      .FIRST_PROG (FIRST_PROG),
      .IDX_REG    (IDX_REG)
   ) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_q (sel_q),
      .sel_d (sel_d),
      .idx   (cfg_image)
   );

   pseq_err_mon u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (core_run),
      .res_valid (core_result_vld),
      .err       (stray_result_err)
   );

endmodule

// File: rtl/pr_program_sequencer_chk.sv
`timescale 1ns/1ps
module pr_program_sequencer_chk #(
   parameter int IDX_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_ready,
   input logic             cfg_done,
   input logic             cfg_req,
   input logic [IDX_W-1:0] cfg_image,
   input logic             core_busy,
   input logic             core_result_vld,
   input logic             core_run,
   input logic             stray_result_err
);

   a_r3_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> cfg_ready);

   a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> !cfg_req);

   a_r5_run_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_run) |-> $past(cfg_done));

   a_r4_image_steady: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> $stable(cfg_image));

   a_r7_image_flips: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_run) |-> (cfg_image != $past(cfg_image)));

   a_r6_stop_on_idle_core: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_run) |-> !$past(core_busy));

   a_r7_no_req_while_run: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> !cfg_req);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stray_result_err |=> stray_result_err);

   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stray_result_err) |-> $past(core_result_vld && !core_run));

endmodule

bind pr_program_sequencer pr_program_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_ready        (cfg_ready),
   .cfg_done         (cfg_done),
   .cfg_req          (cfg_req),
   .cfg_image        (cfg_image),
   .core_busy        (core_busy),
   .core_result_vld  (core_result_vld),
   .core_run         (core_run),
   .stray_result_err (stray_result_err)
);

// File: tb/sim_pr_program_sequencer.sv
`timescale 1ns/1ps
module sim_pr_program_sequencer;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, seq_go, cfg_ready, cfg_done, core_busy, core_result_vld;
   logic       cfg_req, core_run, stray_result_err;
   logic [0:0] cfg_image;

   pr_program_sequencer u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .seq_go           (seq_go),
      .cfg_ready        (cfg_ready),
      .cfg_done         (cfg_done),
      .cfg_req          (cfg_req),
      .cfg_image        (cfg_image),
      .core_busy        (core_busy),
      .core_result_vld  (core_result_vld),
      .core_run         (core_run),
      .stray_result_err (stray_result_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Fields: ready gap, done latency, busy latency, run length, expected image
   localparam int NV = 6;
   localparam logic [39:0] VEC [NV] = '{
      {8'd0, 8'd1, 8'd0, 8'd2, 8'd0},
      {8'd2, 8'd0, 8'd1, 8'd3, 8'd1},
      {8'd1, 8'd5, 8'd0, 8'd2, 8'd0},
      {8'd0, 8'd0, 8'd3, 8'd4, 8'd1},
      {8'd4, 8'd2, 8'd2, 8'd2, 8'd0},
      {8'd0, 8'd3, 8'd0, 8'd5, 8'd1}
   };

   initial begin
      rst_n = 1'b0; seq_go = 1'b0; cfg_ready = 1'b0; cfg_done = 1'b0;
      core_busy = 1'b0; core_result_vld = 1'b0;
      repeat (3) tick();
      chk("R1 req in reset", cfg_req, 0);
      chk("R1 run in reset", core_run, 0);
      chk("R1 err in reset", stray_result_err, 0);
      chk("R1 image in reset", cfg_image, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 run after reset", core_run, 0);
      chk("R1 image after reset", cfg_image, 0);

      // R2: idle ignores a ready engine without a start command
      cfg_ready = 1'b1;
      repeat (5) begin
         tick();
         chk("R2 no request while idle", cfg_req, 0);
      end
      cfg_ready = 1'b0;
      seq_go = 1'b1;
      tick();

      for (int v = 0; v < NV; v++) begin
         int gap, dlat, alat, rlen, eimg;
         gap  = int'(VEC[v][39:32]);
         dlat = int'(VEC[v][31:24]);
         alat = int'(VEC[v][23:16]);
         rlen = int'(VEC[v][15:8]);
         eimg = int'(VEC[v][7:0]);

         repeat (gap) begin
            tick();
            chk("R3 request waits for ready", cfg_req, 0);
         end
         cfg_ready = 1'b1;
         #1;
         chk("R3 request with ready", cfg_req, 1);
         chk("R4 image of request", cfg_image, eimg);
         if (v == 0) seq_go = 1'b0;  // R10: start command dropped
         tick();
         chk("R3 request lasts one cycle", cfg_req, 0);
         cfg_ready = 1'b0;

         repeat (dlat) begin
            chk("R5 run waits for done", core_run, 0);
            tick();
         end
         chk("R5 run low before done", core_run, 0);
         cfg_done = 1'b1;
         tick();
         cfg_done = 1'b0;
         chk("R5 run after done", core_run, 1);

         repeat (alat) begin
            tick();
            chk("R6 run held before busy", core_run, 1);
         end
         core_busy = 1'b1;
         tick();
         core_result_vld = 1'b1;
         tick();
         core_result_vld = 1'b0;
         chk("R6 run held while busy", core_run, 1);
         repeat (rlen) begin
            tick();
            chk("R6 run held while busy", core_run, 1);
            chk("R7 no request while running", cfg_req, 0);
            chk("R4 image steady while running", cfg_image, eimg);
         end
         chk("R9 in-run result no error", stray_result_err, 0);
         core_busy = 1'b0;
         tick();
         chk("R6 run drops after busy low", core_run, 0);
         chk("R7 image switched", cfg_image, eimg ^ 1);
         chk("R10 loop continues", v, v);
      end

      // R8: early done while request still pending
      cfg_done = 1'b1;
      tick();
      cfg_done = 1'b0;
      chk("R8 early done ignored", core_run, 0);
      tick();
      chk("R8 early done ignored", core_run, 0);
      cfg_ready = 1'b1;
      #1;
      chk("R8 request still issued", cfg_req, 1);
      chk("R4 image after six rounds", cfg_image, 0);
      tick();
      cfg_ready = 1'b0;

      // R9: stray result while core idle
      core_result_vld = 1'b1;
      tick();
      core_result_vld = 1'b0;
      chk("R9 stray result sets error", stray_result_err, 1);
      repeat (3) begin
         tick();
         chk("R9 error sticky", stray_result_err, 1);
      end
      cfg_done = 1'b1;
      tick();
      cfg_done = 1'b0;
      chk("R5 run after done", core_run, 1);
      core_busy = 1'b1;
      repeat (2) tick();
      core_busy = 1'b0;
      tick();
      chk("R6 run drops", core_run, 0);
      chk("R9 error survives a run", stray_result_err, 1);

      // R1: reset in the middle of a run
      cfg_ready = 1'b1;
      #1;
      chk("R4 image of next request", cfg_image, 1);
      tick();
      cfg_ready = 1'b0;
      cfg_done = 1'b1;
      tick();
      cfg_done = 1'b0;
      chk("R5 run after done", core_run, 1);
      rst_n = 1'b0;
      #1;
      chk("R1 reset stops run", core_run, 0);
      chk("R1 reset clears error", stray_result_err, 0);
      chk("R1 reset restores image", cfg_image, 0);
      tick();
      rst_n = 1'b1;
      cfg_ready = 1'b1;
      repeat (3) begin
         tick();
         chk("R2 idle again after reset", cfg_req, 0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule